// File: doc/BRIEF.md
# Privileged trap entry unit

This block commits every architectural state change that entering a trap handler requires. It acts in the same clock edge as a one-cycle trap strobe. The caller supplies the trap number, a flag that marks the trap as an interrupt, the faulting address, the PC of the trapped instruction and the current privilege. It also supplies the two delegation masks (one for exceptions, one for interrupts), the status word and the two trap-vector registers. The unit picks supervisor or machine as the handler mode and pushes the interrupt-enable and previous-privilege stack of that mode. It then writes that mode's cause, exception-PC and trap-value registers and produces the handler PC.

Two details shape the stored values. An environment call arrives with one generic number, and the unit rewrites it to the variant for the current privilege before it indexes the delegation mask. The trap value carries the address only for synchronous misalignment, access-fault and page-fault traps.

All committed values hold between strobes. The status fields of the mode that does not take the trap are copied unchanged from the status input.

Top module: `trap_entry_unit`

## Requirements
- R1: During and right after reset, `priv_out` is 3 (machine), `pc_out` is `RESET_PC`, and `stat_out`, the three supervisor registers and the three machine registers are all zero.
- R2: Privilege encoding is U=0, S=1, M=3. A trap goes to supervisor (`priv_out`=1) when `cur_priv` is 0 or 1 and bit `code` of the selected mask is set. The selected mask is `irq_deleg` for interrupts and `exc_deleg` for exceptions. Every other trap, including any trap taken while `cur_priv` is 3, goes to machine (`priv_out`=3).
- R3: A synchronous trap with code 8 is rewritten to code 8, 9 or 11 when `cur_priv` is 0, 1 or 3. The rewritten code is the one that selects the delegation bit and the one that is stored in the cause register. An interrupt with code 8 is not rewritten.
- R4: The trap value equals `trap_addr` for synchronous traps with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. It is zero for every other synchronous code and for every interrupt.
- R5: On supervisor entry, `stat_out` bit 5 takes the old bit 1, bit 8 takes `cur_priv[0]` and bit 1 becomes 0. All other bits are copied from `stat_in`. `s_epc` takes `cur_pc`.
- R6: On machine entry, `stat_out` bit 7 takes the old bit 3, bits 12:11 take `cur_priv` and bit 3 becomes 0. All other bits are copied from `stat_in`. `m_epc` takes `cur_pc`.
- R7: The cause register of the target mode takes the effective code, zero-extended, with bit XLEN-1 equal to `trap_irq`. The cause, EPC and trap-value registers of the other mode keep their previous values.
- R8: `pc_out` is the target mode's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector register's bits 1:0 equal 1, four times the code is added.
- R9: No offset is added for an exception when the vector mode is 1, or for an interrupt when the vector mode is 0, 2 or 3.
- R10: On a cycle without `trap_fire`, all outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_fire | input | 1 | One-cycle strobe: commit a trap entry |
| trap_irq | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_code | input | CODE_W | Trap number |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapped instruction |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| stat_in | input | XLEN | Current status word |
| stvec_in | input | XLEN | Supervisor trap-vector register |
| mtvec_in | input | XLEN | Machine trap-vector register |
| priv_out | output | 2 | Privilege after the trap |
| pc_out | output | XLEN | Handler PC |
| stat_out | output | XLEN | Status word after the trap |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |

## Verification
The bench sets delegation bits that a correct unit must ignore. One case is an exception-mask bit on an interrupt number. The other is a delegation bit while the core is in machine mode. A unit that indexes the wrong mask, or that omits the privilege test, would then land in supervisor. Environment calls are made from all three modes with only the rewritten number delegated. A unit that looks up the generic number 8 would route these traps to the wrong mode and store the wrong cause. The bench also drives vectored and non-vectored modes with both exceptions and interrupts, and uses address-bearing codes on interrupts. These cases catch a unit that offsets exceptions or leaks the address into the trap value. Every trap also re-checks the registers of the mode that was not targeted, so a unit that writes both register sets is reported.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   // status word bit positions (decoded by neighbouring logic)
   localparam int unsigned ST_SIE    = 1;
   localparam int unsigned ST_MIE    = 3;
   localparam int unsigned ST_SPIE   = 5;
   localparam int unsigned ST_MPIE   = 7;
   localparam int unsigned ST_SPP    = 8;
   localparam int unsigned ST_MPP_LO = 11;

   localparam int unsigned ECALL_GENERIC = 8;
   localparam logic [1:0]  VEC_MODE_TABLE = 2'b01;

endpackage

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
   import trap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CODE_W = 5
) (
   input  logic              irq,
   input  logic [CODE_W-1:0] code_in,
   input  logic [1:0]        cur_priv,
   input  logic [XLEN-1:0]   addr,
   output logic [CODE_W-1:0] code_eff,
   output logic [XLEN-1:0]   tval
);

   generate
      if (CODE_W < 4) begin : g_bad_code_w
         $error("trap_cause_decode: CODE_W must be at least 4");
      end
   endgenerate

   logic is_ecall;
   logic addr_class;

   // environment call: generic number plus privilege gives 8/9/11
   assign is_ecall = !irq && (code_in == CODE_W'(ECALL_GENERIC));

   always_comb begin
      code_eff = code_in;
      if (is_ecall) begin
         code_eff = code_in + CODE_W'(cur_priv);
      end
   end

   always_comb begin
      addr_class = 1'b0;
      if (!irq) begin
         case (code_eff)
            CODE_W'(0), CODE_W'(1), CODE_W'(4), CODE_W'(5),
            CODE_W'(6), CODE_W'(7), CODE_W'(12), CODE_W'(13),
            CODE_W'(15): addr_class = 1'b1;
            default:     addr_class = 1'b0;
         endcase
      end
   end

   assign tval = addr_class ? addr : '0;

   // R3: an ecall never leaves the 8..11 window
   always_comb begin
      if (is_ecall) begin
         assert_ecall_range_R3: assert (code_eff >= CODE_W'(8) && code_eff <= CODE_W'(11));
      end
   end

endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
   import trap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CODE_W = 5
) (
   input  logic              irq,
   input  logic [CODE_W-1:0] code,
   input  logic [1:0]        cur_priv,
   input  logic [XLEN-1:0]   exc_deleg,
   input  logic [XLEN-1:0]   irq_deleg,
   output logic              to_super
);

   localparam int unsigned IDX_MAX = XLEN - 1;

   logic [XLEN-1:0] mask;
   logic            low_priv;
   logic            bit_set;

   assign mask     = irq ? irq_deleg : exc_deleg;
   assign low_priv = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);
   assign bit_set  = (32'(code) <= IDX_MAX) ? mask[code] : 1'b0;
   assign to_super = low_priv && bit_set;

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
   import trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 5,
   parameter bit          VECTORED = 1'b1
) (
   input  logic [XLEN-1:0]   tvec,
   input  logic              irq,
   input  logic [CODE_W-1:0] code,
   output logic [XLEN-1:0]   target_pc
);

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign base = {tvec[XLEN-1:2], 2'b00};

   generate
      if (VECTORED) begin : g_vectored
         assign offset = (irq && tvec[1:0] == VEC_MODE_TABLE)
                         ? XLEN'({code, 2'b00}) : '0;
      end else begin : g_direct
         assign offset = '0;
      end
   endgenerate

   assign target_pc = base + offset;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int unsigned    XLEN     = 32,
   parameter int unsigned    CODE_W   = $clog2(XLEN),
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter bit             VECTORED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_fire,
   input  logic              trap_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   trap_addr,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [1:0]        cur_priv,
   input  logic [XLEN-1:0]   exc_deleg,
   input  logic [XLEN-1:0]   irq_deleg,
   input  logic [XLEN-1:0]   stat_in,
   input  logic [XLEN-1:0]   stvec_in,
   input  logic [XLEN-1:0]   mtvec_in,
   output logic [1:0]        priv_out,
   output logic [XLEN-1:0]   pc_out,
   output logic [XLEN-1:0]   stat_out,
   output logic [XLEN-1:0]   s_cause,
   output logic [XLEN-1:0]   s_epc,
   output logic [XLEN-1:0]   s_tval,
   output logic [XLEN-1:0]   m_cause,
   output logic [XLEN-1:0]   m_epc,
   output logic [XLEN-1:0]   m_tval
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_unit: XLEN must be 32 or 64");
      end
      if (CODE_W >= XLEN) begin : g_bad_code
         $error("trap_entry_unit: CODE_W must be below XLEN");
      end
      if (XLEN <= ST_MPP_LO + 1) begin : g_bad_stat
         $error("trap_entry_unit: status word too narrow");
      end
   endgenerate

   logic [CODE_W-1:0] code_eff;
   logic [XLEN-1:0]   tval_c;
   logic              to_super;
   logic [XLEN-1:0]   s_target;
   logic [XLEN-1:0]   m_target;
   logic [XLEN-1:0]   cause_c;
   logic [XLEN-1:0]   stat_nxt;

   trap_cause_decode #(.XLEN(XLEN), .CODE_W(CODE_W)) u_decode (
      .irq      (trap_irq),
      .code_in  (trap_code),
      .cur_priv (cur_priv),
      .addr     (trap_addr),
      .code_eff (code_eff),
      .tval     (tval_c)
   );

   trap_target_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_target (
      .irq       (trap_irq),
      .code      (code_eff),
      .cur_priv  (cur_priv),
      .exc_deleg (exc_deleg),
      .irq_deleg (irq_deleg),
      .to_super  (to_super)
   );

   trap_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTORED(VECTORED)) u_svec (
      .tvec      (stvec_in),
      .irq       (trap_irq),
      .code      (code_eff),
      .target_pc (s_target)
   );

   trap_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTORED(VECTORED)) u_mvec (
      .tvec      (mtvec_in),
      .irq       (trap_irq),
      .code      (code_eff),
      .target_pc (m_target)
   );

   assign cause_c = {trap_irq, (XLEN-1)'(code_eff)};

   always_comb begin
      stat_nxt = stat_in;
      if (to_super) begin
         stat_nxt[ST_SPIE] = stat_in[ST_SIE];
         stat_nxt[ST_SPP]  = cur_priv[0];
         stat_nxt[ST_SIE]  = 1'b0;
      end else begin
         stat_nxt[ST_MPIE]            = stat_in[ST_MIE];
         stat_nxt[ST_MPP_LO +: 2]     = cur_priv;
         stat_nxt[ST_MIE]             = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_out <= PRIV_M;
         pc_out   <= RESET_PC;
         stat_out <= '0;
      end else if (trap_fire) begin
         priv_out <= to_super ? PRIV_S : PRIV_M;
         pc_out   <= to_super ? s_target : m_target;
         stat_out <= stat_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_cause <= '0;
         s_epc   <= '0;
         s_tval  <= '0;
      end else if (trap_fire && to_super) begin
         s_cause <= cause_c;
         s_epc   <= cur_pc;
         s_tval  <= tval_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cause <= '0;
         m_epc   <= '0;
         m_tval  <= '0;
      end else if (trap_fire && !to_super) begin
         m_cause <= cause_c;
         m_epc   <= cur_pc;
         m_tval  <= tval_c;
      end
   end

   // ---------------- assertions ----------------
   assert_mach_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && cur_priv == PRIV_M) |=> (priv_out == PRIV_M));

   assert_sup_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && to_super) |=> (priv_out == PRIV_S && !stat_out[ST_SIE]
         && stat_out[ST_SPIE] == $past(stat_in[ST_SIE]) && s_epc == $past(cur_pc)));

   assert_mach_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && !to_super) |=> (!stat_out[ST_MIE]
         && stat_out[ST_MPIE] == $past(stat_in[ST_MIE])
         && stat_out[ST_MPP_LO +: 2] == $past(cur_priv) && m_epc == $past(cur_pc)));

   assert_cause_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |=> (((priv_out == PRIV_S) ? s_cause[XLEN-1] : m_cause[XLEN-1])
                     == $past(trap_irq)));

   assert_other_mode_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && to_super) |=> ($stable(m_cause) && $stable(m_epc) && $stable(m_tval)));

   assert_irq_no_tval_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && trap_irq) |=> (((priv_out == PRIV_S) ? s_tval : m_tval) == '0));

   assert_pc_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |=> (pc_out[1:0] == 2'b00));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_fire |=> ($stable(priv_out) && $stable(pc_out) && $stable(stat_out)
                      && $stable(s_cause) && $stable(m_cause)));

endmodule

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;

   localparam int XLEN   = 32;
   localparam int CODE_W = 5;
   localparam logic [31:0] RPC = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_fire = 1'b0;
   logic        trap_irq = 1'b0;
   logic [4:0]  trap_code = '0;
   logic [31:0] trap_addr = '0, cur_pc = '0, exc_deleg = '0, irq_deleg = '0;
   logic [31:0] stat_in = '0, stvec_in = '0, mtvec_in = '0;
   logic [1:0]  cur_priv = 2'd3;
   logic [1:0]  priv_out;
   logic [31:0] pc_out, stat_out, s_cause, s_epc, s_tval, m_cause, m_epc, m_tval;

   int n_chk = 0;
   int n_bad = 0;

   logic [1:0]  e_priv;
   logic [31:0] e_pc, e_stat, e_sc, e_se, e_st, e_mc, e_me, e_mt;

   always #2.5 clk = ~clk;

   trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RPC), .VECTORED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .trap_irq(trap_irq),
      .trap_code(trap_code), .trap_addr(trap_addr), .cur_pc(cur_pc), .cur_priv(cur_priv),
      .exc_deleg(exc_deleg), .irq_deleg(irq_deleg), .stat_in(stat_in),
      .stvec_in(stvec_in), .mtvec_in(mtvec_in), .priv_out(priv_out), .pc_out(pc_out),
      .stat_out(stat_out), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
      .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "priv",    {30'd0, priv_out}, {30'd0, e_priv});
      chk(req, "pc",      pc_out,   e_pc);
      chk(req, "status",  stat_out, e_stat);
      chk(req, "s_cause", s_cause,  e_sc);
      chk(req, "s_epc",   s_epc,    e_se);
      chk(req, "s_tval",  s_tval,   e_st);
      chk(req, "m_cause", m_cause,  e_mc);
      chk(req, "m_epc",   m_epc,    e_me);
      chk(req, "m_tval",  m_tval,   e_mt);
   endtask

   // independent expectation from the requirements, then drive and check
   task automatic do_trap(input string req, input logic irq, input int code,
                          input logic [31:0] addr, input logic [31:0] pc,
                          input logic [1:0] priv, input logic [31:0] ed,
                          input logic [31:0] id, input logic [31:0] st,
                          input logic [31:0] sv, input logic [31:0] mv);
      int eff;
      logic to_s, addr_cls;
      logic [31:0] tv, vec, cause;
      eff = code;
      if (!irq && code == 8) eff = (priv == 2'd0) ? 8 : (priv == 2'd1) ? 9 : 11;
      to_s = (priv <= 2'd1) && (irq ? id[eff] : ed[eff]);
      addr_cls = !irq && (eff == 0 || eff == 1 || eff == 4 || eff == 5 || eff == 6 ||
                          eff == 7 || eff == 12 || eff == 13 || eff == 15);
      tv = addr_cls ? addr : 32'd0;
      cause = {irq, 31'(eff)};
      vec = to_s ? sv : mv;
      e_pc = {vec[31:2], 2'b00} + ((irq && vec[1:0] == 2'b01) ? 32'(4 * eff) : 32'd0);
      e_stat = st;
      if (to_s) begin
         e_priv = 2'd1;
         e_stat[5] = st[1]; e_stat[8] = priv[0]; e_stat[1] = 1'b0;
         e_sc = cause; e_se = pc; e_st = tv;
      end else begin
         e_priv = 2'd3;
         e_stat[7] = st[3]; e_stat[12:11] = priv; e_stat[3] = 1'b0;
         e_mc = cause; e_me = pc; e_mt = tv;
      end
      @(negedge clk);
      trap_fire = 1'b1; trap_irq = irq; trap_code = 5'(code); trap_addr = addr;
      cur_pc = pc; cur_priv = priv; exc_deleg = ed; irq_deleg = id;
      stat_in = st; stvec_in = sv; mtvec_in = mv;
      @(negedge clk);
      trap_fire = 1'b0;
      check_all(req);
   endtask

   task automatic t_reset;
      e_priv = 2'd3; e_pc = RPC; e_stat = '0;
      e_sc = '0; e_se = '0; e_st = '0; e_mc = '0; e_me = '0; e_mt = '0;
      check_all("R1");
   endtask

   task automatic t_user_page_fault_delegated;
      // R2 R5 R4: load page fault (13) from U, delegated
      do_trap("R2/R5", 1'b0, 13, 32'hDEAD_B000, 32'h0040_0010, 2'd0,
              32'h0000_2000, 32'h0, 32'h0000_0002, 32'h8000_0101, 32'h9000_0000);
   endtask

   task automatic t_machine_ignores_deleg;
      // R2 R6: same fault in M mode with deleg set goes to M
      do_trap("R2/R6", 1'b0, 13, 32'h1234_5678, 32'h0000_0200, 2'd3,
              32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000A, 32'h8000_0000, 32'h9000_0003);
   endtask

   task automatic t_irq_vectored_super;
      // R8 R7 R4: supervisor timer interrupt 5, vector mode 1
      do_trap("R8", 1'b1, 5, 32'hAAAA_0000, 32'h0040_0100, 2'd1,
              32'h0, 32'h0000_0020, 32'h0000_0002, 32'h8000_1001, 32'h9000_0001);
   endtask

   task automatic t_irq_uses_irq_mask;
      // R2: exception mask bit set for 5, interrupt mask clear -> machine, vectored
      do_trap("R2", 1'b1, 5, 32'h0, 32'h0040_0200, 2'd0,
              32'h0000_0020, 32'h0, 32'h0000_0008, 32'h8000_1001, 32'h9000_0401);
   endtask

   task automatic t_ecall_remap;
      // R3: only rewritten number is delegated
      do_trap("R3", 1'b0, 8, 32'h5555_5555, 32'h0000_0300, 2'd1,
              32'h0000_0200, 32'h0, 32'h0000_0002, 32'h8000_2000, 32'h9000_2000);
      do_trap("R3", 1'b0, 8, 32'h5555_5555, 32'h0000_0304, 2'd0,
              32'h0000_0200, 32'h0, 32'h0, 32'h8000_2000, 32'h9000_2000);
      do_trap("R3", 1'b0, 8, 32'h5555_5555, 32'h0000_0308, 2'd3,
              32'h0000_0800, 32'h0, 32'h0, 32'h8000_2000, 32'h9000_2000);
      do_trap("R3", 1'b0, 8, 32'h5555_5555, 32'h0000_030C, 2'd0,
              32'h0000_0100, 32'h0, 32'h0000_0022, 32'h8000_2000, 32'h9000_2000);
   endtask

   task automatic t_tval_cases;
      // R4: illegal instruction (2) -> zero; misaligned fetch (0) -> address
      do_trap("R4", 1'b0, 2, 32'hCAFE_0001, 32'h0000_0400, 2'd3,
              32'h0, 32'h0, 32'h0, 32'h0, 32'h9000_0000);
      do_trap("R4", 1'b0, 0, 32'hCAFE_0002, 32'h0000_0404, 2'd0,
              32'h0000_0001, 32'h0, 32'h0, 32'h8000_3000, 32'h9000_0000);
      do_trap("R4", 1'b0, 7, 32'hCAFE_0003, 32'h0000_0408, 2'd1,
              32'h0, 32'h0, 32'h0, 32'h8000_3000, 32'h9000_0000);
      // interrupt with an address-class number keeps trap value zero
      do_trap("R4", 1'b1, 13, 32'hCAFE_0004, 32'h0000_040C, 2'd1,
              32'h0, 32'h0000_2000, 32'h0, 32'h8000_3001, 32'h9000_0000);
   endtask

   task automatic t_vector_modes;
      // R9: exception with mode 1, interrupt with modes 0,2,3
      do_trap("R9", 1'b0, 4, 32'h0000_0011, 32'h0000_0500, 2'd3,
              32'h0, 32'h0, 32'h0, 32'h0, 32'h9000_0101);
      do_trap("R9", 1'b1, 7, 32'h0, 32'h0000_0504, 2'd3,
              32'h0, 32'h0, 32'h0, 32'h0, 32'h9000_0200);
      do_trap("R9", 1'b1, 7, 32'h0, 32'h0000_0508, 2'd3,
              32'h0, 32'h0, 32'h0, 32'h0, 32'h9000_0202);
      do_trap("R9", 1'b1, 9, 32'h0, 32'h0000_050C, 2'd0,
              32'h0, 32'h0000_0200, 32'h0, 32'h8000_0403, 32'h0);
   endtask

   task automatic t_hold;
      // R10: inputs move but no strobe
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         trap_irq = i[0]; trap_code = 5'(i + 3); trap_addr = 32'(i * 77);
         cur_pc = 32'hF000_0000 + 32'(i); cur_priv = 2'(i);
         exc_deleg = '1; irq_deleg = '1; stat_in = '1;
         stvec_in = 32'h7000_0001; mtvec_in = 32'h6000_0001;
      end
      @(negedge clk);
      check_all("R10");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_user_page_fault_delegated();
      t_machine_ignores_deleg();
      t_irq_vectored_super();
      t_irq_uses_irq_mask();
      t_ecall_remap();
      t_tval_cases();
      t_vector_modes();
      t_hold();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule